// File: doc/BRIEF.md
# Condition Code Evaluator

This block turns the operands and result of one ALU operation into a new processor status word. Each cycle the issue stage presents the source operand, the destination operand, the result, the upper word of a multiply product, an operation class, an operand size, a per-instruction mask of flags to update, a flag that marks the set/clear-flags instructions, and the current status word. One clock later the block returns the merged status word with a valid strobe. The ALU itself is outside this block.

The negative, zero, overflow and carry flags are formed according to the operand width. The sign is taken from bit 7, 15 or 31, and the zero test covers only the low 8, 16 or 32 result bits. Subtract and compare use an inverted source sign and an inverted carry, so the carry flag means borrow. Moves produce only sign and zero. Both multiplies judge overflow from the upper product word. An extended-arithmetic bit in the status word makes the zero flag sticky, and that bit is cleared by every instruction except the set/clear-flags group.

Top module: `ccEvalTop`

## Requirements
- R1: The sign used for the N flag of add, subtract, compare and move is result bit 7, 15 or 31 for size code 0, 1 or 2 respectively; size code 3 behaves as code 2. Status word bit positions are C=0, V=1, Z=2, N=3, X=4.
- R2: For add, subtract, compare and move, Z is set when the low 8, 16 or 32 result bits (per size code 0, 1, 2) are all zero; higher result bits are ignored.
- R3: For add (class code 0), V is set when the source and destination signs are equal and the result sign differs from them; C is set when both signs are 1, or when either is 1 and the result sign is 0.
- R4: For subtract (class code 1) and compare (class code 2), the add rules of R3 are applied with the source sign inverted, and the resulting carry is inverted before it is written (C is a borrow).
- R5: For move (class code 3, and the unused codes 6 and 7), N and Z come from the result and V and C are written as 0.
- R6: For signed multiply (class code 4), V is set unless the upper word equals the sign extension of the 32-bit result (all ones for a negative result, zero otherwise); N and Z come from the full 32-bit result and C is written as 0.
- R7: For unsigned multiply (class code 5), V is set when the upper word is nonzero; N and Z come from the full 32-bit result and C is written as 0.
- R8: When X is set in the incoming status word, the new Z can be 1 only if the incoming Z was 1.
- R9: X in the output is 0 unless the keep-X input is high, in which case X passes through unchanged.
- R10: The update mask input carries bits {N,Z,V,C} at positions 3..0; a flag whose mask bit is 0 keeps its incoming value, and status bits 5 and above always pass through unchanged.
- R11: The output valid is high exactly one cycle after an input valid and the status output updates only then; after reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opClass | input | 3 | Operation class code |
| opSize | input | 2 | Operand size code |
| srcIn | input | 32 | Source operand |
| dstIn | input | 32 | Destination operand |
| resIn | input | 32 | ALU result (low product word for multiplies) |
| mulHigh | input | 32 | Upper product word |
| updMask | input | 4 | Flags to update, {N,Z,V,C} |
| keepX | input | 1 | High for the set/clear-flags instructions |
| ccsIn | input | 8 | Current status word |
| outValid | output | 1 | New status word valid |
| ccsOut | output | 8 | New status word |

## Verification
An instruction issued with X already set both reads the old X to decide whether Z may rise and clears X in the same write. The two rules therefore meet in a single cycle. The bench provokes this with zero and nonzero results under each combination of incoming X and Z and of keep-X. It judges Z and X of the same output word against a reference model that keeps the two rules separate. The same word is also checked for bits outside the update mask, so a wrong merge order shows up as a mismatch in that word.

// File: rtl/ccEvalPkg.sv
package ccEvalPkg;
  localparam int DATA_W    = 32;
  localparam int NUM_SIZES = 3;
  localparam int SIZE_W    = $clog2(NUM_SIZES);
  localparam int NUM_UPD   = 4;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_X = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_MOVE = 3'd3,
    OP_MULS = 3'd4,
    OP_MULU = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opClass_e;

  typedef struct packed {
    logic              load;
    logic              arith;
    logic              invSrc;
    logic              mulS;
    logic              mulU;
    logic [SIZE_W-1:0] sizeSel;
  } ccStrobe_t;
endpackage

// File: rtl/ccEvalCtrl.sv
module ccEvalCtrl
  import ccEvalPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opClass,
  input  logic [1:0] opSize,
  output ccStrobe_t  strb,
  output logic       outValid
);
  opClass_e cls;

  always_comb begin
    cls          = opClass_e'(opClass);
    strb         = '0;
    strb.load    = inValid;
    strb.sizeSel = (opSize > 2'd2) ? SIZE_W'(2) : SIZE_W'(opSize);
    unique case (cls)
      OP_ADD:           strb.arith = 1'b1;
      OP_SUB, OP_CMP: begin
        strb.arith  = 1'b1;
        strb.invSrc = 1'b1;
      end
      OP_MULS:          strb.mulS = 1'b1;
      OP_MULU:          strb.mulU = 1'b1;
      default:          strb.arith = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r4_one_class: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.arith, strb.mulS, strb.mulU}) <= 1);
endmodule

// File: rtl/ccEvalDp.sv
module ccEvalDp
  import ccEvalPkg::*;
#(
  parameter int CCS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ccStrobe_t          strb,
  input  logic [DATA_W-1:0]  srcIn,
  input  logic [DATA_W-1:0]  dstIn,
  input  logic [DATA_W-1:0]  resIn,
  input  logic [DATA_W-1:0]  mulHigh,
  input  logic [NUM_UPD-1:0] updMask,
  input  logic               keepX,
  input  logic [CCS_W-1:0]   ccsIn,
  output logic [CCS_W-1:0]   ccsOut
);
  logic [NUM_SIZES-1:0] laneSrcSign, laneDstSign, laneResSign, laneZero;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SIZES; gi++) begin : gLane
      localparam int LW = 8 << gi;
      assign laneSrcSign[gi] = srcIn[LW-1];
      assign laneDstSign[gi] = dstIn[LW-1];
      assign laneResSign[gi] = resIn[LW-1];
      assign laneZero[gi]    = (resIn[LW-1:0] == '0);
    end
  endgenerate

  logic srcSign, dstSign, resSign, resZero;
  logic fullNeg, fullZero, mulSOvf, mulUOvf;

  always_comb begin
    srcSign  = laneSrcSign[strb.sizeSel];
    dstSign  = laneDstSign[strb.sizeSel];
    resSign  = laneResSign[strb.sizeSel];
    resZero  = laneZero[strb.sizeSel];
    fullNeg  = resIn[DATA_W-1];
    fullZero = (resIn == '0);
    mulSOvf  = (mulHigh != {DATA_W{fullNeg}});
    mulUOvf  = |mulHigh;
  end

  logic sEff, carryRaw;
  logic fN, fZ, fV, fC;
  logic [CCS_W-1:0] wrMask, newFlags, ccsNext;

  always_comb begin
    sEff     = srcSign ^ strb.invSrc;
    carryRaw = (sEff & dstSign) | ((sEff | dstSign) & ~resSign);
    fN = resSign;
    fZ = resZero;
    fV = 1'b0;
    fC = 1'b0;
    if (strb.mulS || strb.mulU) begin
      fN = fullNeg;
      fZ = fullZero;
      fV = strb.mulS ? mulSOvf : mulUOvf;
    end else if (strb.arith) begin
      fV = (sEff == dstSign) && (resSign != sEff);
      fC = carryRaw ^ strb.invSrc;
    end
    if (ccsIn[FLAG_X]) fZ = fZ & ccsIn[FLAG_Z];

    wrMask                = '0;
    wrMask[NUM_UPD-1:0]   = updMask;
    wrMask[FLAG_X]        = ~keepX;
    newFlags              = '0;
    newFlags[FLAG_N]      = fN;
    newFlags[FLAG_Z]      = fZ;
    newFlags[FLAG_V]      = fV;
    newFlags[FLAG_C]      = fC;
    ccsNext = (ccsIn & ~wrMask) | (newFlags & wrMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ccsOut <= '0;
    else if (strb.load) ccsOut <= ccsNext;
  end

  a_r10_high_bits_pass: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> ccsOut[CCS_W-1:FLAG_X+1] == $past(ccsIn[CCS_W-1:FLAG_X+1]));
  a_r9_x_rule: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> ccsOut[FLAG_X] == ($past(keepX) ? $past(ccsIn[FLAG_X]) : 1'b0));
  a_r8_sticky_z: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.load) && $past(ccsIn[FLAG_X]) && !$past(ccsIn[FLAG_Z])) |-> !ccsOut[FLAG_Z]);
  a_r7_mulu_clean: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.load) && $past(strb.mulU) && $past(updMask[FLAG_V]) && ($past(mulHigh) == '0))
      |-> !ccsOut[FLAG_V]);
  a_r5_move_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.load) && !$past(strb.arith) && $past(updMask[FLAG_C])) |-> !ccsOut[FLAG_C]);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.load) |-> $stable(ccsOut));
endmodule

// File: rtl/ccEvalTop.sv
module ccEvalTop
  import ccEvalPkg::*;
#(
  parameter int CCS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opClass,
  input  logic [1:0]       opSize,
  input  logic [31:0]      srcIn,
  input  logic [31:0]      dstIn,
  input  logic [31:0]      resIn,
  input  logic [31:0]      mulHigh,
  input  logic [3:0]       updMask,
  input  logic             keepX,
  input  logic [CCS_W-1:0] ccsIn,
  output logic             outValid,
  output logic [CCS_W-1:0] ccsOut
);
  ccStrobe_t strb;

  ccEvalCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opClass(opClass),
    .opSize(opSize), .strb(strb), .outValid(outValid)
  );

  ccEvalDp #(.CCS_W(CCS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcIn(srcIn), .dstIn(dstIn),
    .resIn(resIn), .mulHigh(mulHigh), .updMask(updMask), .keepX(keepX),
    .ccsIn(ccsIn), .ccsOut(ccsOut)
  );
endmodule

// File: tb/sim_ccEvalTop.sv
module sim_ccEvalTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opClass = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] srcIn = '0, dstIn = '0, resIn = '0, mulHigh = '0;
  logic [3:0]  updMask = '0;
  logic        keepX = 1'b0;
  logic [7:0]  ccsIn = '0;
  logic        outValid;
  logic [7:0]  ccsOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [7:0] exp; logic [7:0] tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  ccEvalTop u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opClass(opClass), .opSize(opSize),
    .srcIn(srcIn), .dstIn(dstIn), .resIn(resIn), .mulHigh(mulHigh),
    .updMask(updMask), .keepX(keepX), .ccsIn(ccsIn), .outValid(outValid), .ccsOut(ccsOut)
  );

  function automatic string tagName(input logic [7:0] t);
    case (t)
      8'd1: return "R1";   8'd2: return "R2";   8'd3: return "R3";
      8'd4: return "R4";   8'd5: return "R5";   8'd6: return "R6";
      8'd7: return "R7";   8'd8: return "R8";   8'd9: return "R9";
      8'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [7:0] refCcs(input int cls, input int sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] mh, input logic [3:0] um, input logic kx, input logic [7:0] ci);
    int w;
    longint m, sv, dv, rv, hi, lo;
    logic n, z, v, c;
    logic [7:0] wm, f;
    w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    sv = longint'(s) & m; if (sv > hi) sv = sv - (m + 1);
    dv = longint'(d) & m; if (dv > hi) dv = dv - (m + 1);
    n = r[w-1];
    z = ((longint'(r) & m) == 0);
    v = 1'b0; c = 1'b0;
    if (cls == 0) begin
      c  = (((longint'(s) & m) + (longint'(d) & m)) >> w) != 0;
      rv = sv + dv; v = (rv > hi) || (rv < lo);
    end else if (cls == 1 || cls == 2) begin
      c  = (longint'(s) & m) > (longint'(d) & m);
      rv = dv - sv; v = (rv > hi) || (rv < lo);
    end else if (cls == 4 || cls == 5) begin
      n = r[31]; z = (r == 0);
      v = (cls == 4) ? (mh != (r[31] ? 32'hFFFF_FFFF : 32'h0)) : (mh != 0);
    end
    if (ci[4] && !ci[2]) z = 1'b0;
    wm = {3'b000, ~kx, um};
    f  = {4'b0000, n, z, v, c};
    return (ci & ~wm) | (f & wm);
  endfunction

  task automatic issue(input int cls, input int sz, input logic [31:0] s, input logic [31:0] d,
      input logic [31:0] r, input logic [31:0] mh, input logic [3:0] um, input logic kx,
      input logic [7:0] ci, input int req);
    item_t it;
    @(negedge clk);
    opClass = 3'(cls); opSize = 2'(sz); srcIn = s; dstIn = d; resIn = r; mulHigh = mh;
    updMask = um; keepX = kx; ccsIn = ci; inValid = 1'b1;
    it.exp = refCcs(cls, sz, s, d, r, mh, um, kx, ci);
    it.tag = 8'(req);
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      ccsIn = 8'hFF;
    end
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      item_t it;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R11: output valid with nothing pending, actual=1 expected=0");
      end else begin
        it = sbq.pop_front();
        if (ccsOut !== it.exp) begin
          bad++;
          $display("FAIL %s: ccsOut actual=%02h expected=%02h", tagName(it.tag), ccsOut, it.exp);
        end
      end
    end
  end

  task automatic runClass(input int cls, input int req);
    logic [31:0] sp [8];
    logic [31:0] dp [8];
    sp = '{32'h0000_007F, 32'h0000_0080, 32'h0000_FFFF, 32'h7FFF_FFFF,
           32'h0, 32'h1234_5678, 32'h0000_0005, 32'h8000_8080};
    dp = '{32'h0000_0001, 32'h0000_0080, 32'h0000_0001, 32'h0000_0001,
           32'h0, 32'h9ABC_DEF0, 32'h0000_0007, 32'h8000_8080};
    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] r, mh;
        logic [63:0] p;
        mh = 32'h0;
        case (cls)
          0: r = sp[k] + dp[k];
          1, 2: r = dp[k] - sp[k];
          4: begin p = 64'($signed(sp[k]) * $signed(dp[k])); r = p[31:0]; mh = p[63:32]; end
          5: begin p = 64'(sp[k]) * 64'(dp[k]); r = p[31:0]; mh = p[63:32]; end
          default: r = sp[k] ^ dp[k];
        endcase
        issue(cls, sz, sp[k], dp[k], r, mh, 4'hF, 1'b0, 8'h0F, req);
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          total++; bad++;
          $display("FAIL R11: watchdog expired, actual=running expected=done");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 1'b0 || ccsOut !== 8'h00) begin
      bad++;
      $display("FAIL R11: reset state actual=%b/%02h expected=0/00", outValid, ccsOut);
    end
    rstN = 1'b1;
    idle(2);

    runClass(0, 3);
    runClass(1, 4);
    runClass(2, 4);
    runClass(3, 5);
    runClass(6, 5);
    runClass(4, 6);
    runClass(5, 7);

    // R1: sign position follows size code
    issue(3, 0, 0, 0, 32'h0000_0080, 0, 4'hF, 0, 8'h00, 1);
    issue(3, 1, 0, 0, 32'h0000_0080, 0, 4'hF, 0, 8'h00, 1);
    issue(3, 1, 0, 0, 32'h0000_8000, 0, 4'hF, 0, 8'h00, 1);
    issue(3, 3, 0, 0, 32'h8000_0000, 0, 4'hF, 0, 8'h00, 1);
    // R2: zero test limited to size
    issue(3, 0, 0, 0, 32'h0000_0100, 0, 4'hF, 0, 8'h00, 2);
    issue(3, 1, 0, 0, 32'h0001_0000, 0, 4'hF, 0, 8'h00, 2);
    issue(3, 2, 0, 0, 32'h0001_0000, 0, 4'hF, 0, 8'h00, 2);
    // R6: sign extension in upper word is not overflow
    issue(4, 2, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hF, 0, 8'h00, 6);
    issue(4, 2, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 4'hF, 0, 8'h00, 6);
    // R7: nonzero upper word
    issue(5, 2, 0, 0, 32'h0, 32'h0000_0001, 4'hF, 0, 8'h00, 7);
    // R8 with R9 in the same cycle: sticky Z and X clear
    issue(3, 2, 0, 0, 32'h0, 0, 4'hF, 0, 8'h10, 8);
    issue(3, 2, 0, 0, 32'h0, 0, 4'hF, 0, 8'h14, 8);
    issue(3, 2, 0, 0, 32'h5, 0, 4'hF, 0, 8'h14, 8);
    issue(0, 2, 32'h1, 32'hFFFF_FFFF, 32'h0, 0, 4'hF, 1, 8'h10, 8);
    issue(0, 2, 32'h1, 32'hFFFF_FFFF, 32'h0, 0, 4'hF, 1, 8'h14, 9);
    issue(3, 2, 0, 0, 32'h1, 0, 4'h0, 1, 8'h10, 9);
    issue(3, 2, 0, 0, 32'h1, 0, 4'h0, 0, 8'h1F, 9);
    // R10: masked-out flags and high bits pass through
    issue(3, 2, 0, 0, 32'h0, 0, 4'h0, 0, 8'hE5, 10);
    issue(0, 0, 32'hFF, 32'h01, 32'h100, 0, 4'b1000, 0, 8'hA7, 10);
    issue(1, 0, 32'h01, 32'h00, 32'hFFFF_FFFF, 0, 4'b0011, 0, 8'h4C, 10);
    // R11: idle cycles produce no output and hold the word
    idle(3);
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R11: idle output valid actual=%b expected=0", outValid);
    end
    issue(3, 2, 0, 0, 32'h1, 0, 4'hF, 0, 8'h00, 11);
    idle(3);
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R11: pending results actual=%0d expected=0", sbq.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule